// File: doc/BRIEF.md
# Virtual Page Mapper With Bypass

This block turns a 32-bit virtual word address into a 32-bit real address. A page holds 1024 words, so the upper 22 bits of an address name a virtual page and the lower 10 bits are the offset within it. The block first chooses which address space to translate in. The low region (addresses below 2^28 words) always uses space 0. Every other address uses the space id that is loaded for the requesting processor.

A programmable bypass window skips translation. It is selected by comparing page bits under a mask against a pattern. Its real page is built bit by bit from a base register and from the virtual page. All other addresses are looked up in a small fully associative table of (space id, virtual page) entries. The block also enforces that user mode may read the low kernel region but may not write it.

Each request returns a real address, four page flags and a fault code a fixed three cycles after it is sampled. Software-side agents use the config port to program the window and the space ids, the load port to install mappings, and the flush port to drop every mapping of one space.

Top module: `vpm_top`

## Requirements
- R1: A request sampled at rising edge N produces a one-cycle `rspValid` pulse after edge N+3, with all results valid in that cycle. While `rspValid` is low, `rspAddr`, `rspFlags` and `rspFault` read zero.
- R2: On every response with fault code 0, `rspAddr[9:0]` equals the offset `reqAddr[9:0]` of the request.
- R3: An address is in the bypass window when its page bits `reqAddr[31:10]` equal the pattern register in every position where the mask register holds 1.
- R4: A bypassed request returns a real page that takes each bit from the base register where the mask bit is 1 and from the virtual page where it is 0. It returns flags 0 and fault 0, whatever its mode or direction.
- R5: A non-bypassed address with `reqAddr[31:28]==0` is translated in space 0. Any other non-bypassed address is translated in the space id loaded for `reqProc`.
- R6: A table hit returns `{real page, offset}` and the entry's flags. The flag bits are: bit 3 shared, bit 2 write enable, bit 1 dirty, bit 0 spare.
- R7: A non-bypassed lookup with no matching valid entry returns fault 1 (map miss), with `rspAddr` 0 and `rspFlags` 0.
- R8: A non-bypassed user-mode write to the low region returns fault 2 with address and flags 0. This takes precedence over a miss. User-mode reads of the low region translate normally.
- R9: A write that hits an entry whose write-enable flag (bit 2) is clear returns fault 3 with address and flags 0. A read of the same entry succeeds.
- R10: A load whose (space id, page) already exists rewrites that entry in place. Otherwise the load fills the slot at a round-robin pointer, which advances only on such fills. After 16 new fills past a given entry, that entry is evicted.
- R11: A flush invalidates every valid entry whose space id equals `flAid` and leaves other entries untouched.
- R12: Config writes select by `cfgSel`: 0 mask, 1 pattern, 2 base (all 22 bits), 3 space id of processor `cfgProc` (low 10 bits of `cfgData`).
- R13: After reset the mask, pattern, base and space ids are zero and the table is empty. Every address therefore bypasses with an identity mapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Translation request strobe |
| reqProc | input | 2 | Requesting processor number |
| reqAddr | input | 32 | Virtual word address |
| reqWrite | input | 1 | 1 for write access |
| reqUser | input | 1 | 1 for user mode |
| cfgWe | input | 1 | Config register write strobe |
| cfgSel | input | 2 | Config register select |
| cfgProc | input | 2 | Processor whose space id is written |
| cfgData | input | 22 | Config write data |
| ldValid | input | 1 | Table load strobe |
| ldAid | input | 10 | Space id of loaded entry |
| ldVpage | input | 22 | Virtual page of loaded entry |
| ldRpage | input | 22 | Real page of loaded entry |
| ldFlags | input | 4 | Flags of loaded entry |
| flValid | input | 1 | Flush strobe |
| flAid | input | 10 | Space id to flush |
| rspValid | output | 1 | Response strobe |
| rspAddr | output | 32 | Real word address |
| rspFlags | output | 4 | Page flags |
| rspFault | output | 3 | Fault code |

## Verification
Every translation result is due three edges after the edge that samples the request. The bench drives each request at a falling edge and lets it be sampled at the next rising edge. It checks at the falling edge after the second following rising edge that `rspValid` is still low. It then reads every result at the falling edge after the third rising edge, and checks one cycle later that the pulse has ended. Config, load and flush writes take effect at the edge that samples them, so each one is completed a full cycle before any lookup that depends on it.

// File: rtl/vpm_pkg.sv
package vpm_pkg;
  localparam int VA_W     = 32;
  localparam int OFF_W    = 10;
  localparam int VP_W     = VA_W - OFF_W;
  localparam int FLAG_W   = 4;
  localparam int FAULT_W  = 3;
  localparam int LOW_SPAN = 28;
  localparam int REGION_W = VA_W - LOW_SPAN;

  localparam int FLG_SHARED = 3;
  localparam int FLG_WTEN   = 2;
  localparam int FLG_DIRTY  = 1;
  localparam int FLG_SPARE  = 0;

  typedef enum logic [FAULT_W-1:0] {
    FLT_NONE   = 3'd0,
    FLT_MISS   = 3'd1,
    FLT_KWRITE = 3'd2,
    FLT_WPROT  = 3'd3
  } fault_e;

  typedef enum logic [1:0] {
    CFG_MASK    = 2'd0,
    CFG_PATTERN = 2'd1,
    CFG_BASE    = 2'd2,
    CFG_SPACE   = 2'd3
  } cfgSel_e;

  typedef enum logic [1:0] {
    OUT_ZERO   = 2'd0,
    OUT_BYPASS = 2'd1,
    OUT_ENTRY  = 2'd2
  } outSel_e;

  // control -> datapath
  typedef struct packed {
    logic    s1Cap;
    logic    tblWrite;
    logic    tblFlush;
    outSel_e outSel;
  } strobes_t;

  // datapath -> control, taken from the third pipeline stage
  typedef struct packed {
    logic bypass;
    logic lowRegion;
    logic hit;
    logic wtEnable;
    logic isWrite;
    logic isUser;
  } status_t;
endpackage

// File: rtl/vpm_dpath.sv
module vpm_dpath
  import vpm_pkg::*;
#(
  parameter int NPROC   = 4,
  parameter int AID_W   = 10,
  parameter int ENTRIES = 16,
  localparam int PROC_W = (NPROC > 1) ? $clog2(NPROC) : 1,
  localparam int SLOT_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [VA_W-1:0]   reqAddr,
  input  logic [PROC_W-1:0] reqProc,
  input  logic              reqWrite,
  input  logic              reqUser,
  input  logic              cfgWe,
  input  logic [1:0]        cfgSel,
  input  logic [PROC_W-1:0] cfgProc,
  input  logic [VP_W-1:0]   cfgData,
  input  logic [AID_W-1:0]  ldAid,
  input  logic [VP_W-1:0]   ldVpage,
  input  logic [VP_W-1:0]   ldRpage,
  input  logic [FLAG_W-1:0] ldFlags,
  input  logic [AID_W-1:0]  flAid,
  input  strobes_t          stb,
  input  logic [SLOT_W-1:0] slot,
  output logic              ldExists,
  output logic [SLOT_W-1:0] ldExistIdx,
  output status_t           st,
  output logic [VA_W-1:0]   rspAddr,
  output logic [FLAG_W-1:0] rspFlags
);

  // programmable registers
  logic [VP_W-1:0] bypMask, bypPattern, bypBase;
  logic [NPROC-1:0][AID_W-1:0] spaceId;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bypMask    <= '0;
      bypPattern <= '0;
      bypBase    <= '0;
      spaceId    <= '0;
    end else if (cfgWe) begin
      case (cfgSel_e'(cfgSel))
        CFG_MASK:    bypMask    <= cfgData;
        CFG_PATTERN: bypPattern <= cfgData;
        CFG_BASE:    bypBase    <= cfgData;
        default:     spaceId[cfgProc] <= cfgData[AID_W-1:0];
      endcase
    end
  end

  // entry table
  logic [ENTRIES-1:0]             entValid;
  logic [ENTRIES-1:0][AID_W-1:0]  entAid;
  logic [ENTRIES-1:0][VP_W-1:0]   entVp;
  logic [ENTRIES-1:0][VP_W-1:0]   entRp;
  logic [ENTRIES-1:0][FLAG_W-1:0] entFlags;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      entValid <= '0;
      entAid   <= '0;
      entVp    <= '0;
      entRp    <= '0;
      entFlags <= '0;
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (stb.tblFlush && entValid[i] && entAid[i] == flAid)
          entValid[i] <= 1'b0;
        if (stb.tblWrite && slot == SLOT_W'(i)) begin
          entValid[i] <= 1'b1;
          entAid[i]   <= ldAid;
          entVp[i]    <= ldVpage;
          entRp[i]    <= ldRpage;
          entFlags[i] <= ldFlags;
        end
      end
    end
  end

  // load-side match, so a repeated pair lands on its own slot
  logic [ENTRIES-1:0] ldHitVec;
  always_comb begin
    ldExistIdx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      ldHitVec[i] = entValid[i] && entAid[i] == ldAid && entVp[i] == ldVpage;
      if (ldHitVec[i]) ldExistIdx = SLOT_W'(i);
    end
  end
  assign ldExists = |ldHitVec;

  // stage 1: space selection
  logic [VP_W-1:0]  s1Vp;
  logic [OFF_W-1:0] s1Off;
  logic [AID_W-1:0] s1Aid;
  logic             s1Write, s1User, s1Low;
  logic             reqLow;

  assign reqLow = (reqAddr[VA_W-1 -: REGION_W] == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      s1Vp <= '0; s1Off <= '0; s1Aid <= '0;
      s1Write <= 1'b0; s1User <= 1'b0; s1Low <= 1'b0;
    end else if (stb.s1Cap) begin
      s1Vp    <= reqAddr[VA_W-1:OFF_W];
      s1Off   <= reqAddr[OFF_W-1:0];
      s1Aid   <= reqLow ? '0 : spaceId[reqProc];
      s1Write <= reqWrite;
      s1User  <= reqUser;
      s1Low   <= reqLow;
    end
  end

  // stage 2: window test and associative compare
  logic [ENTRIES-1:0] s2Match;
  logic [VP_W-1:0]    s2BypRp;
  logic [OFF_W-1:0]   s2Off;
  logic               s2Bypass, s2Write, s2User, s2Low;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      s2Match <= '0; s2BypRp <= '0; s2Off <= '0;
      s2Bypass <= 1'b0; s2Write <= 1'b0; s2User <= 1'b0; s2Low <= 1'b0;
    end else begin
      for (int i = 0; i < ENTRIES; i++)
        s2Match[i] <= entValid[i] && entAid[i] == s1Aid && entVp[i] == s1Vp;
      s2Bypass <= ((s1Vp ^ bypPattern) & bypMask) == '0;
      s2BypRp  <= (bypBase & bypMask) | (s1Vp & ~bypMask);
      s2Off    <= s1Off;
      s2Write  <= s1Write;
      s2User   <= s1User;
      s2Low    <= s1Low;
    end
  end

  // stage 3: read out the matching entry
  logic [VP_W-1:0]   muxRp;
  logic [FLAG_W-1:0] muxFlags;
  always_comb begin
    muxRp    = '0;
    muxFlags = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      muxRp    = muxRp    | (entRp[i]    & {VP_W{s2Match[i]}});
      muxFlags = muxFlags | (entFlags[i] & {FLAG_W{s2Match[i]}});
    end
  end

  logic [VP_W-1:0]   s3Rp, s3BypRp;
  logic [FLAG_W-1:0] s3Flags;
  logic [OFF_W-1:0]  s3Off;
  logic              s3Hit, s3Bypass, s3Write, s3User, s3Low;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      s3Rp <= '0; s3BypRp <= '0; s3Flags <= '0; s3Off <= '0;
      s3Hit <= 1'b0; s3Bypass <= 1'b0; s3Write <= 1'b0; s3User <= 1'b0; s3Low <= 1'b0;
    end else begin
      s3Rp     <= muxRp;
      s3Flags  <= muxFlags;
      s3Hit    <= |s2Match;
      s3BypRp  <= s2BypRp;
      s3Off    <= s2Off;
      s3Bypass <= s2Bypass;
      s3Write  <= s2Write;
      s3User   <= s2User;
      s3Low    <= s2Low;
    end
  end

  assign st = '{bypass: s3Bypass, lowRegion: s3Low, hit: s3Hit,
                wtEnable: s3Flags[FLG_WTEN], isWrite: s3Write, isUser: s3User};

  // output register, steered by control
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspAddr  <= '0;
      rspFlags <= '0;
    end else begin
      case (stb.outSel)
        OUT_BYPASS: begin rspAddr <= {s3BypRp, s3Off}; rspFlags <= '0;      end
        OUT_ENTRY:  begin rspAddr <= {s3Rp, s3Off};    rspFlags <= s3Flags; end
        default:    begin rspAddr <= '0;               rspFlags <= '0;      end
      endcase
    end
  end

  // R10
  nodup_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(s2Match));
  // R10
  load_lands_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.tblWrite |=> entValid[$past(slot)]);
  // R11
  flush_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.tblFlush && !stb.tblWrite) |=>
      ((entValid & ~$past(entValid)) == '0));

endmodule

// File: rtl/vpm_ctrl.sv
module vpm_ctrl
  import vpm_pkg::*;
#(
  parameter int ENTRIES = 16,
  localparam int SLOT_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  input  logic               ldValid,
  input  logic               flValid,
  input  status_t            st,
  input  logic               ldExists,
  input  logic [SLOT_W-1:0]  ldExistIdx,
  output strobes_t           stb,
  output logic [SLOT_W-1:0]  slot,
  output logic               rspValid,
  output logic [FAULT_W-1:0] rspFault
);

  logic s1Valid, s2Valid, s3Valid;
  logic [SLOT_W-1:0] rrPtr;
  fault_e faultNow;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      s1Valid <= 1'b0;
      s2Valid <= 1'b0;
      s3Valid <= 1'b0;
    end else begin
      s1Valid <= reqValid;
      s2Valid <= s1Valid;
      s3Valid <= s2Valid;
    end
  end

  // priority: window, kernel write, miss, write-enable
  always_comb begin
    if (st.bypass)                                  faultNow = FLT_NONE;
    else if (st.isUser && st.isWrite && st.lowRegion) faultNow = FLT_KWRITE;
    else if (!st.hit)                               faultNow = FLT_MISS;
    else if (st.isWrite && !st.wtEnable)            faultNow = FLT_WPROT;
    else                                            faultNow = FLT_NONE;
  end

  always_comb begin
    stb.s1Cap    = reqValid;
    stb.tblWrite = ldValid;
    stb.tblFlush = flValid;
    if (!s3Valid)                 stb.outSel = OUT_ZERO;
    else if (st.bypass)           stb.outSel = OUT_BYPASS;
    else if (faultNow != FLT_NONE) stb.outSel = OUT_ZERO;
    else                          stb.outSel = OUT_ENTRY;
  end

  assign slot = ldExists ? ldExistIdx : rrPtr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rrPtr <= '0;
    end else if (ldValid && !ldExists) begin
      rrPtr <= (rrPtr == SLOT_W'(ENTRIES - 1)) ? '0 : rrPtr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspFault <= FLT_NONE;
    end else begin
      rspValid <= s3Valid;
      rspFault <= s3Valid ? faultNow : FLT_NONE;
    end
  end

  // edges since reset, used to bound $past in the latency check
  logic [2:0] sinceRst;
  always_ff @(posedge clk) begin
    if (!rstN) sinceRst <= '0;
    else if (sinceRst != 3'd7) sinceRst <= sinceRst + 3'd1;
  end

  // R1
  latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst >= 3'd4) |-> (rspValid == $past(reqValid, 4)));
  // R4
  bypass_nofault_chk: assert property (@(posedge clk) disable iff (!rstN)
    (s3Valid && st.bypass) |=> (rspValid && rspFault == FLT_NONE));
  // R8
  kwrite_chk: assert property (@(posedge clk) disable iff (!rstN)
    (s3Valid && !st.bypass && st.isUser && st.isWrite && st.lowRegion)
      |=> (rspFault == FLT_KWRITE));
  // R7
  miss_chk: assert property (@(posedge clk) disable iff (!rstN)
    (s3Valid && !st.bypass && !st.hit && !(st.isUser && st.isWrite && st.lowRegion))
      |=> (rspFault == FLT_MISS));

endmodule

// File: rtl/vpm_top.sv
module vpm_top
  import vpm_pkg::*;
#(
  parameter int NPROC   = 4,
  parameter int AID_W   = 10,
  parameter int ENTRIES = 16,
  localparam int PROC_W = (NPROC > 1) ? $clog2(NPROC) : 1,
  localparam int SLOT_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  input  logic [PROC_W-1:0]  reqProc,
  input  logic [VA_W-1:0]    reqAddr,
  input  logic               reqWrite,
  input  logic               reqUser,
  input  logic               cfgWe,
  input  logic [1:0]         cfgSel,
  input  logic [PROC_W-1:0]  cfgProc,
  input  logic [VP_W-1:0]    cfgData,
  input  logic               ldValid,
  input  logic [AID_W-1:0]   ldAid,
  input  logic [VP_W-1:0]    ldVpage,
  input  logic [VP_W-1:0]    ldRpage,
  input  logic [FLAG_W-1:0]  ldFlags,
  input  logic               flValid,
  input  logic [AID_W-1:0]   flAid,
  output logic               rspValid,
  output logic [VA_W-1:0]    rspAddr,
  output logic [FLAG_W-1:0]  rspFlags,
  output logic [FAULT_W-1:0] rspFault
);

  strobes_t          stb;
  status_t           st;
  logic [SLOT_W-1:0] slot, ldExistIdx;
  logic              ldExists;

  vpm_ctrl #(.ENTRIES(ENTRIES)) ctrl_i (
    .clk, .rstN, .reqValid, .ldValid, .flValid,
    .st, .ldExists, .ldExistIdx,
    .stb, .slot, .rspValid, .rspFault
  );

  vpm_dpath #(.NPROC(NPROC), .AID_W(AID_W), .ENTRIES(ENTRIES)) dpath_i (
    .clk, .rstN, .reqAddr, .reqProc, .reqWrite, .reqUser,
    .cfgWe, .cfgSel, .cfgProc, .cfgData,
    .ldAid, .ldVpage, .ldRpage, .ldFlags, .flAid,
    .stb, .slot, .ldExists, .ldExistIdx, .st,
    .rspAddr, .rspFlags
  );

  // R7
  fault_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspFault != FLT_NONE) |-> (rspAddr == '0 && rspFlags == '0));
  // R1
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rspValid |-> (rspAddr == '0 && rspFlags == '0 && rspFault == FLT_NONE));

endmodule

// File: tb/vpm_top_tb_top.sv
module vpm_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 0, reqWrite = 0, reqUser = 0;
  logic [1:0]  reqProc = 0;
  logic [31:0] reqAddr = 0;
  logic        cfgWe = 0;
  logic [1:0]  cfgSel = 0, cfgProc = 0;
  logic [21:0] cfgData = 0;
  logic        ldValid = 0, flValid = 0;
  logic [9:0]  ldAid = 0, flAid = 0;
  logic [21:0] ldVpage = 0, ldRpage = 0;
  logic [3:0]  ldFlags = 0;
  logic        rspValid;
  logic [31:0] rspAddr;
  logic [3:0]  rspFlags;
  logic [2:0]  rspFault;

  int errors = 0, checks = 0, cycles = 0;
  logic [21:0] mMask = 0, mPat = 0, mBase = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vpm_top dut_i (
    .clk, .rstN, .reqValid, .reqProc, .reqAddr, .reqWrite, .reqUser,
    .cfgWe, .cfgSel, .cfgProc, .cfgData,
    .ldValid, .ldAid, .ldVpage, .ldRpage, .ldFlags, .flValid, .flAid,
    .rspValid, .rspAddr, .rspFlags, .rspFault
  );

  task automatic chk(string rq, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic cfgWrite(logic [1:0] sel, logic [1:0] proc, logic [21:0] data);
    @(negedge clk);
    cfgWe = 1; cfgSel = sel; cfgProc = proc; cfgData = data;
    @(negedge clk);
    cfgWe = 0;
    if (sel == 2'd0) mMask = data;
    if (sel == 2'd1) mPat  = data;
    if (sel == 2'd2) mBase = data;
  endtask

  task automatic loadEntry(logic [9:0] aid, logic [21:0] vp, logic [21:0] rp, logic [3:0] fl);
    @(negedge clk);
    ldValid = 1; ldAid = aid; ldVpage = vp; ldRpage = rp; ldFlags = fl;
    @(negedge clk);
    ldValid = 0;
  endtask

  task automatic flushSpace(logic [9:0] aid);
    @(negedge clk);
    flValid = 1; flAid = aid;
    @(negedge clk);
    flValid = 0;
  endtask

  // one request; results due after the third edge following the sampling edge
  task automatic lookup(string rq, logic [1:0] proc, logic [31:0] va, logic wr, logic usr,
                        logic [31:0] expAddr, logic [3:0] expFlags, logic [2:0] expFault);
    @(negedge clk);
    reqValid = 1; reqProc = proc; reqAddr = va; reqWrite = wr; reqUser = usr;
    @(negedge clk);               // edge N sampled it
    reqValid = 0;
    @(negedge clk);               // after N+1
    @(negedge clk);               // after N+2
    chk({rq, " R1 not early"}, 64'(rspValid), 64'd0);
    @(negedge clk);               // after N+3
    chk({rq, " R1 valid"}, 64'(rspValid), 64'd1);
    chk({rq, " fault"}, 64'(rspFault), 64'(expFault));
    chk({rq, " addr"}, 64'(rspAddr), 64'(expAddr));
    chk({rq, " flags"}, 64'(rspFlags), 64'(expFlags));
    @(negedge clk);
    chk({rq, " R1 single pulse"}, 64'(rspValid), 64'd0);
  endtask

  function automatic logic [31:0] bypAddr(logic [31:0] va);
    return {(mBase & mMask) | (va[31:10] & ~mMask), va[9:0]};
  endfunction

  task automatic tReset();
    chk("R13 reset valid", 64'(rspValid), 64'd0);
    chk("R13 reset addr", 64'(rspAddr), 64'd0);
    chk("R13 reset fault", 64'(rspFault), 64'd0);
    // zero mask: everything bypasses as identity, even a user write to low region
    lookup("R13 R4 identity", 2'd0, 32'h0000_0457, 1'b1, 1'b1, 32'h0000_0457, 4'h0, 3'd0);
    lookup("R13 identity high", 2'd3, 32'h9ABC_DEF1, 1'b0, 1'b0, 32'h9ABC_DEF1, 4'h0, 3'd0);
  endtask

  task automatic tBypass();
    // R12 mask/pattern/base program the window on the top six page bits
    cfgWrite(2'd0, 2'd0, 22'h3F0000);
    cfgWrite(2'd1, 2'd0, 22'h3F0000);
    cfgWrite(2'd2, 2'd0, 22'h2A5555);
    lookup("R3 R4 R12 window user write", 2'd1, 32'hFC01_23AB, 1'b1, 1'b1,
           bypAddr(32'hFC01_23AB), 4'h0, 3'd0);
    lookup("R3 R4 window read", 2'd2, 32'hFFFF_FC05, 1'b0, 1'b0,
           bypAddr(32'hFFFF_FC05), 4'h0, 3'd0);
    // one pattern bit differs: not bypassed, table empty
    lookup("R3 R7 outside window", 2'd0, 32'hF801_0000, 1'b0, 1'b0, 32'h0, 4'h0, 3'd1);
  endtask

  task automatic tSpace();
    cfgWrite(2'd3, 2'd1, 22'd5);  // R12 space id of proc 1
    cfgWrite(2'd3, 2'd2, 22'd7);
    loadEntry(10'd5, 22'h040001, 22'h001111, 4'b0100);
    lookup("R5 R6 R2 proc1 hit", 2'd1, 32'h1000_0000 | 32'h0000_0400 | 32'h12F, 1'b0, 1'b0,
           {22'h001111, 10'h12F}, 4'b0100, 3'd0);
    lookup("R5 R7 proc2 other space", 2'd2, 32'h1000_052F, 1'b0, 1'b0, 32'h0, 4'h0, 3'd1);
    loadEntry(10'd0, 22'h000010, 22'h00ABCD, 4'b1111);
    lookup("R5 low region space 0", 2'd2, 32'h0000_403F, 1'b0, 1'b0,
           {22'h00ABCD, 10'h03F}, 4'b1111, 3'd0);
  endtask

  task automatic tProtect();
    lookup("R8 user read low", 2'd1, 32'h0000_4001, 1'b0, 1'b1,
           {22'h00ABCD, 10'h001}, 4'b1111, 3'd0);
    lookup("R8 user write low", 2'd1, 32'h0000_4001, 1'b1, 1'b1, 32'h0, 4'h0, 3'd2);
    lookup("R8 precedence over miss", 2'd0, 32'h0123_4567, 1'b1, 1'b1, 32'h0, 4'h0, 3'd2);
    lookup("R9 kernel write low", 2'd1, 32'h0000_4002, 1'b1, 1'b0,
           {22'h00ABCD, 10'h002}, 4'b1111, 3'd0);
    loadEntry(10'd5, 22'h040002, 22'h003333, 4'b1000);
    lookup("R9 read no write enable", 2'd1, 32'h1000_0810, 1'b0, 1'b0,
           {22'h003333, 10'h010}, 4'b1000, 3'd0);
    lookup("R9 write no write enable", 2'd1, 32'h1000_0810, 1'b1, 1'b0, 32'h0, 4'h0, 3'd3);
  endtask

  task automatic tOverwriteFlush();
    loadEntry(10'd5, 22'h040001, 22'h002222, 4'b0110);
    lookup("R10 overwrite in place", 2'd1, 32'h1000_0401, 1'b1, 1'b0,
           {22'h002222, 10'h001}, 4'b0110, 3'd0);
    flushSpace(10'd5);
    lookup("R11 flushed entry", 2'd1, 32'h1000_0401, 1'b0, 1'b0, 32'h0, 4'h0, 3'd1);
    lookup("R11 flushed second", 2'd1, 32'h1000_0810, 1'b0, 1'b0, 32'h0, 4'h0, 3'd1);
    lookup("R11 other space kept", 2'd3, 32'h0000_4004, 1'b0, 1'b0,
           {22'h00ABCD, 10'h004}, 4'b1111, 3'd0);
  endtask

  task automatic tReplace();
    flushSpace(10'd0);
    cfgWrite(2'd3, 2'd3, 22'd9);
    for (int i = 0; i < 17; i++)
      loadEntry(10'd9, 22'h100000 + 22'(i), 22'h300000 + 22'(i), 4'b0100);
    lookup("R10 oldest evicted", 2'd3, 32'h4000_0000, 1'b0, 1'b0, 32'h0, 4'h0, 3'd1);
    lookup("R10 second kept", 2'd3, 32'h4000_0400, 1'b0, 1'b0,
           {22'h300001, 10'h0}, 4'b0100, 3'd0);
    lookup("R10 newest kept", 2'd3, 32'h4000_4000 | 32'h7, 1'b0, 1'b0,
           {22'h300010, 10'h7}, 4'b0100, 3'd0);
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected<=%0d", cycles, WATCHDOG);
      finishRun();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tBypass();
    tSpace();
    tProtect();
    tOverwriteFlush();
    tReplace();
    repeat (2) @(negedge clk);
    finishRun();
  end
endmodule